// File: doc/BRIEF.md
# Host configuration bank and memory window decoder

This block is the always-present configuration area of a memory-mapped peripheral card that sits on an 8-bit host. It occupies sixteen I/O locations starting at a fixed base of 0x90. Through them the host reads a fixed firmware version number and uses four free scratch bytes. It also picks which internal I/O controller is banked into the shared controller space, and sets the physical memory window that the card answers to. The bank is decoded whatever controller is banked in, so the host can always reach it.

The card has no chip-enable pin. The top five bits of a 22-bit memory address are compared with a programmable 5-bit window register. When they match and a memory strobe is active, the card is selected, and the low 17 bits are passed on as the offset into the card's 128KB window. On hosts with a narrow address bus, those five lines therefore act as chip enables. The polarity of each line is set by the matching register bit.

Top module: `cfgbank_top`

## Requirements
- R1: An I/O access is decoded by the bank, and `io_hit` is high, exactly when `io_addr[7:4]` equals 0x9. This holds regardless of the value in the device-select register. `io_rdata` is 0x00 unless `io_rd` is high and `io_hit` is high. Writes outside 0x90–0x9F change no register.
- R2: Offsets 0, 1 and 2 return the firmware revision, minor and major numbers, which default to 0x03, 0x02 and 0x01. Writes to these offsets have no effect.
- R3: Offsets 3 to 6 are four independent scratch bytes. A byte written to one reads back unchanged and leaves the other three untouched.
- R4: Offset 7 is the device-select register. A write stores all 8 bits. A read returns the stored value, and `dev_sel` presents it from the cycle after the write.
- R5: Offset 8 is the window register. A write stores only `io_wdata[4:0]`, and a read returns those 5 bits with bits 7:5 as zero.
- R6: Offsets 9 to 15 read as 0x00, and writes to them change no register.
- R7: A synchronous active-high reset sets the scratch bytes and the device select to 0x00 and the window register to 8.
- R8: `mem_sel` is high only when `mem_rd` or `mem_wr` is high and `mem_addr[21:17]` equals the window register. `mem_offset` always equals `mem_addr[16:0]`.
- R9: A write to the window register changes the decoding of `mem_sel` from the clock cycle after the write edge, and not before it.
- R10: With the reset value, the card answers from 0x100000 to 0x11FFFF inclusive, and not at 0x0FFFFF or 0x120000. Each address line must match the level of its register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 8 | I/O bus address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, zero when not selected |
| io_hit | output | 1 | I/O address falls inside the configuration bank |
| mem_addr | input | 22 | Host physical memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| mem_sel | output | 1 | Card selected for this memory access |
| mem_offset | output | 17 | Offset into the card's 128KB window |
| dev_sel | output | 8 | Currently banked I/O controller number |

## Verification
The hardest case to reach is the one-cycle boundary of a window change. The memory address has to match the new window value while the write that stores it is still in flight. The bench drives the window write and a matching memory strobe in the same cycle. It samples `mem_sel` once before the write edge, when it must still follow the old window, and once after the edge, when it must follow the new one. Polarity is covered by programming window values whose bits differ from the reset pattern, and then probing addresses that differ from the window in a single line.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned IO_AW     = 8;
  localparam int unsigned MEM_AW    = 22;
  localparam int unsigned WIN_W     = 5;
  localparam int unsigned LOCAL_W   = MEM_AW - WIN_W;
  localparam int unsigned OFS_W     = 4;
  localparam int unsigned N_SCRATCH = 4;

  // register offsets inside the bank
  localparam logic [OFS_W-1:0] OFS_REV   = 4'd0;
  localparam logic [OFS_W-1:0] OFS_MINOR = 4'd1;
  localparam logic [OFS_W-1:0] OFS_MAJOR = 4'd2;
  localparam logic [OFS_W-1:0] OFS_SCR0  = 4'd3;
  localparam logic [OFS_W-1:0] OFS_DEV   = 4'd7;
  localparam logic [OFS_W-1:0] OFS_WIN   = 4'd8;

  // bank decode: upper address bits equal the upper bits of the base
  function automatic logic io_in_bank(input logic [IO_AW-1:0] addr,
                                      input logic [IO_AW-1:0] base);
    return addr[IO_AW-1:OFS_W] == base[IO_AW-1:OFS_W];
  endfunction

  // window match: each high address line must equal the register bit
  function automatic logic win_match(input logic [MEM_AW-1:0] addr,
                                     input logic [WIN_W-1:0]  win);
    return (addr[MEM_AW-1:LOCAL_W] ^ win) == '0;
  endfunction

  // scratch slot test
  function automatic logic is_scratch(input logic [OFS_W-1:0] ofs);
    return (ofs >= OFS_SCR0) && (ofs < OFS_SCR0 + OFS_W'(N_SCRATCH));
  endfunction
endpackage

// File: rtl/cfgbank_io_dec.sv
module cfgbank_io_dec
  import cfgbank_pkg::*;
#(
  parameter logic [IO_AW-1:0] BASE = 8'h90
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_rd,
  input  logic             io_wr,
  output logic             hit,
  output logic [OFS_W-1:0] ofs,
  output logic             rd_en,
  output logic             wr_en
);
  always_comb begin
    hit   = io_in_bank(io_addr, BASE);
    ofs   = io_addr[OFS_W-1:0];
    rd_en = hit && io_rd;
    wr_en = hit && io_wr;
  end
endmodule

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
  import cfgbank_pkg::*;
#(
  parameter logic [DW-1:0]    VER_MAJOR = 8'd1,
  parameter logic [DW-1:0]    VER_MINOR = 8'd2,
  parameter logic [DW-1:0]    VER_REV   = 8'd3,
  parameter logic [WIN_W-1:0] WIN_RESET = 5'd8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    dev_q,
  output logic [WIN_W-1:0] win_q
);
  logic [DW-1:0] scr_q [N_SCRATCH];

  // scratch bytes, one per slot
  for (genvar k = 0; k < N_SCRATCH; k++) begin : g_scr
    localparam logic [OFS_W-1:0] MY_OFS = OFS_SCR0 + OFS_W'(k);
    always_ff @(posedge clk) begin
      if (rst)                          scr_q[k] <= '0;
      else if (wr_en && ofs == MY_OFS)  scr_q[k] <= wdata;
    end
  end

  // device select
  always_ff @(posedge clk) begin
    if (rst)                            dev_q <= '0;
    else if (wr_en && ofs == OFS_DEV)   dev_q <= wdata;
  end

  // window register keeps only its low bits
  always_ff @(posedge clk) begin
    if (rst)                            win_q <= WIN_RESET;
    else if (wr_en && ofs == OFS_WIN)   win_q <= wdata[WIN_W-1:0];
  end

  // read multiplexer
  always_comb begin
    rdata = '0;
    unique case (ofs)
      OFS_REV:   rdata = VER_REV;
      OFS_MINOR: rdata = VER_MINOR;
      OFS_MAJOR: rdata = VER_MAJOR;
      OFS_DEV:   rdata = dev_q;
      OFS_WIN:   rdata = {{(DW-WIN_W){1'b0}}, win_q};
      default: begin
        if (is_scratch(ofs)) begin
          for (int k = 0; k < N_SCRATCH; k++) begin
            if (ofs == OFS_SCR0 + OFS_W'(k)) rdata = scr_q[k];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/cfgbank_win_dec.sv
module cfgbank_win_dec
  import cfgbank_pkg::*;
(
  input  logic [MEM_AW-1:0]  mem_addr,
  input  logic               mem_rd,
  input  logic               mem_wr,
  input  logic [WIN_W-1:0]   win_q,
  output logic               addr_match,
  output logic               mem_sel,
  output logic [LOCAL_W-1:0] mem_offset
);
  always_comb begin
    addr_match = win_match(mem_addr, win_q);
    mem_sel    = addr_match && (mem_rd || mem_wr);
    mem_offset = mem_addr[LOCAL_W-1:0];
  end
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter logic [IO_AW-1:0] IO_BASE   = 8'h90,
  parameter logic [DW-1:0]    VER_MAJOR = 8'd1,
  parameter logic [DW-1:0]    VER_MINOR = 8'd2,
  parameter logic [DW-1:0]    VER_REV   = 8'd3,
  parameter logic [WIN_W-1:0] WIN_RESET = 5'd8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IO_AW-1:0]   io_addr,
  input  logic               io_rd,
  input  logic               io_wr,
  input  logic [DW-1:0]      io_wdata,
  output logic [DW-1:0]      io_rdata,
  output logic               io_hit,
  input  logic [MEM_AW-1:0]  mem_addr,
  input  logic               mem_rd,
  input  logic               mem_wr,
  output logic               mem_sel,
  output logic [LOCAL_W-1:0] mem_offset,
  output logic [DW-1:0]      dev_sel
);
  logic [OFS_W-1:0] io_ofs;
  logic             io_rd_en;
  logic             io_wr_en;
  logic [DW-1:0]    reg_rdata;
  logic [WIN_W-1:0] win_q;
  logic             addr_match;

  cfgbank_io_dec #(.BASE(IO_BASE)) u_io (
    .io_addr (io_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .hit     (io_hit),
    .ofs     (io_ofs),
    .rd_en   (io_rd_en),
    .wr_en   (io_wr_en)
  );

  cfgbank_regs #(
    .VER_MAJOR (VER_MAJOR),
    .VER_MINOR (VER_MINOR),
    .VER_REV   (VER_REV),
    .WIN_RESET (WIN_RESET)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (io_wr_en),
    .ofs   (io_ofs),
    .wdata (io_wdata),
    .rdata (reg_rdata),
    .dev_q (dev_sel),
    .win_q (win_q)
  );

  cfgbank_win_dec u_win (
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .win_q      (win_q),
    .addr_match (addr_match),
    .mem_sel    (mem_sel),
    .mem_offset (mem_offset)
  );

  assign io_rdata = io_rd_en ? reg_rdata : '0;
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
  import cfgbank_pkg::*;
#(
  parameter logic [IO_AW-1:0] IO_BASE   = 8'h90,
  parameter logic [DW-1:0]    VER_MAJOR = 8'd1,
  parameter logic [WIN_W-1:0] WIN_RESET = 5'd8
) (
  input logic              clk,
  input logic              rst,
  input logic [IO_AW-1:0]  io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [DW-1:0]     io_wdata,
  input logic [DW-1:0]     io_rdata,
  input logic              io_hit,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_sel,
  input logic              addr_match,
  input logic [WIN_W-1:0]  win_q,
  input logic [DW-1:0]     dev_sel
);
  assert_sel_needs_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    mem_sel |-> (mem_rd || mem_wr));

  assert_sel_needs_match_R8: assert property (@(posedge clk) disable iff (rst)
    mem_sel |-> (addr_match && mem_addr[MEM_AW-1:LOCAL_W] == win_q));

  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && io_hit) |-> io_rdata == '0);

  assert_major_read_R2: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == IO_BASE + 8'd2) |-> io_rdata == VER_MAJOR);

  assert_win_store_R5: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == IO_BASE + 8'd8) |=> win_q == $past(io_wdata[WIN_W-1:0]));

  assert_dev_store_R4: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == IO_BASE + 8'd7) |=> dev_sel == $past(io_wdata));

  assert_reset_vals_R7: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (win_q == WIN_RESET && dev_sel == '0));
endmodule

bind cfgbank_top cfgbank_chk #(
  .IO_BASE   (IO_BASE),
  .VER_MAJOR (VER_MAJOR),
  .WIN_RESET (WIN_RESET)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .io_addr    (io_addr),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .io_hit     (io_hit),
  .mem_addr   (mem_addr),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_sel    (mem_sel),
  .addr_match (addr_match),
  .win_q      (win_q),
  .dev_sel    (dev_sel)
);

// File: tb/cfgbank_top_tb_top.sv
module cfgbank_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_hit;
  logic [21:0] mem_addr = '0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic        mem_sel;
  logic [16:0] mem_offset;
  logic [7:0]  dev_sel;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfgbank_top dut_i (
    .clk(clk), .rst(rst),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_sel(mem_sel), .mem_offset(mem_offset), .dev_sel(dev_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one write cycle: drive after falling edge, stored at next rising edge
  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  // memory probe: returns mem_sel for an address with a read strobe
  task automatic mem_probe(input logic [21:0] a, output logic s);
    @(negedge clk);
    mem_addr = a; mem_rd = 1'b1;
    #1 s = mem_sel;
    mem_rd = 1'b0;
  endtask

  function automatic logic model_match(input logic [21:0] a, input logic [4:0] w);
    return a[21:17] == w;   // bench model: exact equality of the top five lines
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 3; k <= 6; k++) begin
      io_read(8'h90 + 8'(k), d);
      check("R7 scratch reset", d, 8'h00);
    end
    io_read(8'h97, d); check("R7 device reset", d, 8'h00);
    io_read(8'h98, d); check("R7 window reset", d, 8'h08);
    check("R7 dev_sel reset", dev_sel, 8'h00);
  endtask

  task automatic t_version;
    logic [7:0] d;
    io_read(8'h90, d); check("R2 revision", d, 8'h03);
    io_read(8'h91, d); check("R2 minor", d, 8'h02);
    io_read(8'h92, d); check("R2 major", d, 8'h01);
    io_write(8'h90, 8'hAA); io_write(8'h91, 8'hBB); io_write(8'h92, 8'hCC);
    io_read(8'h90, d); check("R2 revision after write", d, 8'h03);
    io_read(8'h91, d); check("R2 minor after write", d, 8'h02);
    io_read(8'h92, d); check("R2 major after write", d, 8'h01);
  endtask

  task automatic t_scratch;
    logic [7:0] d;
    logic [7:0] pat [4];
    pat[0] = 8'h5A; pat[1] = 8'hA5; pat[2] = 8'hFF; pat[3] = 8'h3C;
    for (int k = 0; k < 4; k++) io_write(8'h93 + 8'(k), pat[k]);
    for (int k = 0; k < 4; k++) begin
      io_read(8'h93 + 8'(k), d); check("R3 scratch readback", d, pat[k]);
    end
    io_write(8'h94, 8'h00);
    io_read(8'h93, d); check("R3 neighbour below untouched", d, 8'h5A);
    io_read(8'h95, d); check("R3 neighbour above untouched", d, 8'hFF);
    io_read(8'h94, d); check("R3 cleared slot", d, 8'h00);
  endtask

  task automatic t_device;
    logic [7:0] d;
    @(negedge clk);
    io_addr = 8'h97; io_wdata = 8'hC3; io_wr = 1'b1;
    #1 check("R4 dev_sel before edge", dev_sel, 8'h00);
    @(negedge clk);
    io_wr = 1'b0;
    check("R4 dev_sel after edge", dev_sel, 8'hC3);
    io_read(8'h97, d); check("R4 device readback", d, 8'hC3);
    // R1: bank still visible with another controller selected
    io_read(8'h92, d); check("R1 bank reachable with device banked", d, 8'h01);
  endtask

  task automatic t_window_reg;
    logic [7:0] d;
    io_write(8'h98, 8'hF5);
    io_read(8'h98, d); check("R5 only low five bits kept", d, 8'h15);
    io_write(8'h98, 8'h08);
    io_read(8'h98, d); check("R5 window restored", d, 8'h08);
  endtask

  task automatic t_unused;
    logic [7:0] d;
    for (int k = 9; k < 16; k++) io_write(8'h90 + 8'(k), 8'hEE);
    for (int k = 9; k < 16; k++) begin
      io_read(8'h90 + 8'(k), d); check("R6 unused offset reads zero", d, 8'h00);
    end
    io_read(8'h98, d); check("R6 window untouched by unused writes", d, 8'h08);
    io_read(8'h97, d); check("R6 device untouched by unused writes", d, 8'hC3);
  endtask

  task automatic t_outside;
    logic [7:0] d;
    @(negedge clk);
    io_addr = 8'h88; io_rd = 1'b1;
    #1 check("R1 io_hit low below bank", io_hit, 1'b0);
    check("R1 rdata zero outside", io_rdata, 8'h00);
    io_addr = 8'h9F;
    #1 check("R1 io_hit high at top of bank", io_hit, 1'b1);
    io_addr = 8'hA0;
    #1 check("R1 io_hit low above bank", io_hit, 1'b0);
    io_rd = 1'b0;
    io_write(8'h87, 8'h77);  // would alias device offset
    io_write(8'hA8, 8'h1F);  // would alias window offset
    io_read(8'h97, d); check("R1 device untouched by outside write", d, 8'hC3);
    io_read(8'h98, d); check("R1 window untouched by outside write", d, 8'h08);
    @(negedge clk);
    io_addr = 8'h92;
    #1 check("R1 rdata zero without read strobe", io_rdata, 8'h00);
  endtask

  task automatic t_window_default;
    logic s;
    mem_probe(22'h100000, s); check("R10 window low edge", s, 1'b1);
    mem_probe(22'h11FFFF, s); check("R10 window high edge", s, 1'b1);
    mem_probe(22'h0FFFFF, s); check("R10 just below window", s, 1'b0);
    mem_probe(22'h120000, s); check("R10 just above window", s, 1'b0);
    mem_probe(22'h300000, s); check("R10 top line must be low", s, 1'b0);
    @(negedge clk);
    mem_addr = 22'h10ABCD; mem_rd = 1'b0; mem_wr = 1'b0;
    #1 check("R8 no strobe no select", mem_sel, 1'b0);
    check("R8 offset passthrough", mem_offset, 17'h0ABCD);
    mem_wr = 1'b1;
    #1 check("R8 write strobe selects", mem_sel, 1'b1);
    mem_wr = 1'b0;
  endtask

  task automatic t_window_switch;
    logic s;
    // write new window 0x17 while probing an address in it
    @(negedge clk);
    io_addr = 8'h98; io_wdata = 8'h17; io_wr = 1'b1;
    mem_addr = {5'h17, 17'h00042}; mem_rd = 1'b1;
    #1 check("R9 old window still decides before edge", mem_sel, 1'b0);
    @(negedge clk);
    io_wr = 1'b0;
    #1 check("R9 new window active after edge", mem_sel,
             model_match(mem_addr, 5'h17));
    mem_rd = 1'b0;
    for (int b = 0; b < 5; b++) begin
      mem_probe({5'h17 ^ (5'd1 << b), 17'h1FFFF}, s);
      check("R10 single line mismatch deselects", s, 1'b0);
    end
    mem_probe({5'h17, 17'h1FFFF}, s); check("R8 match at new window", s, 1'b1);
    mem_probe(22'h100000, s); check("R8 old window no longer selected", s, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_version();
    t_scratch();
    t_device();
    t_window_reg();
    t_unused();
    t_outside();
    t_window_default();
    t_window_switch();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule